// File: doc/BRIEF.md
# Programmable Chip-Select Address Decoder

This block turns each bus address into a set of active-low select lines for external memories and peripherals. It holds a bank of programmable windows. Each window has a base address, a compare mask, a valid flag, a data-width flag (8 or 16 bits) and a read-only flag. An address hits a window when every address bit enabled by the mask equals the matching bit of the base. Every valid window that is hit drives its select line low. The block also reports the data width that the bus-sizing logic should use for the access.

Out of reset, window 0 acts as the boot window. It is valid, it has an all-zero mask so it covers the whole address space, and its width comes from a boot-width pin that is sampled while reset is held. The other windows start invalid, and software must program them before they can act. The block keeps one region for internal registers: the top 4 KiB of the address space. No external select ever fires there, and a register-select output is raised instead. A write that hits a read-only window is blocked. No select fires, no acknowledge is given, and a bus error is raised when the bus-error enable input is high. Wait-state timing, the bus-error timer and a software register interface are outside this block. A plain configuration write port stands in for the register interface.

Top module: `cs_decoder`

## Requirements
- R1: While reset is held, window 0 becomes valid with an all-zero mask, so it matches every address outside the register region. All other windows become invalid, read-write and 16 bits wide.
- R2: Window 0's width comes from `boot_wide_i` sampled during reset. A value of 0 gives 8 bits (`bus_wide_o`=0) and a value of 1 gives 16 bits (`bus_wide_o`=1).
- R3: The addresses 0xFFF000 to 0xFFFFFF form the register region, meaning address bits [23:12] are all ones. An access there keeps every `cs_n_o` bit high, sets `reg_sel_o`, sets `ack_o` and reports 16 bits.
- R4: An invalid window never drives its select low, even when the address meets its base and mask.
- R5: Window k is hit when ((addr ^ base_k) & mask_k) == 0 and the window is valid. Bit k of `cs_n_o` goes low during an active access that hits window k.
- R6: Overlapping windows are not arbitrated. Every hit window drives its select line low at the same time.
- R7: `bus_wide_o` gives the width of the lowest-indexed hit window. It reports 16 bits when no valid window is hit.
- R8: A write (`write_i`=1) that hits any valid read-only window keeps every select high and `ack_o` low. It sets `berr_o` exactly when `berr_en_i` is 1.
- R9: Timing of an access:
  - The address and direction are captured on a clock edge at which `as_i` is high.
  - Outputs are active only while `as_i` is still high after that edge.
  - Once `as_i` is low, all selects are high and `ack_o`, `reg_sel_o` and `berr_o` are low.
- R10: A read from a read-only window drives its select low and sets `ack_o`.
- R11: A configuration write (`cfg_we_i`=1) on a clock edge replaces all fields of window `cfg_idx_i`, including window 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_wide_i | input | 1 | Boot window width, sampled during reset (1 = 16-bit) |
| as_i | input | 1 | Address strobe, active high |
| write_i | input | 1 | Access direction, 1 = write |
| addr_i | input | 24 | Bus address |
| berr_en_i | input | 1 | Bus-error enable for protection violations |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_idx_i | input | 4 | Window index to configure |
| cfg_base_i | input | 24 | Window base address |
| cfg_mask_i | input | 24 | Window compare mask |
| cfg_valid_i | input | 1 | Window valid flag |
| cfg_wide_i | input | 1 | Window width, 1 = 16-bit |
| cfg_ro_i | input | 1 | Window read-only flag |
| cs_n_o | output | 16 | Active-low select lines, one per window |
| reg_sel_o | output | 1 | Internal register-region select |
| bus_wide_o | output | 1 | Width of current access, 1 = 16-bit |
| ack_o | output | 1 | Transfer acknowledge |
| berr_o | output | 1 | Bus error on a protection violation |

## Verification
The bench uses the default parameters: 16 windows, a 24-bit address and a 12-bit register page. With these values the register region sits at 0xFFF000. This makes the exact boundary reachable: an access to 0xFFEFFF still falls to the boot window. All sixteen windows exist, so the bench can place overlapping windows at indices 5 and 7 to check lowest-index width selection, and a read-only window at index 9. Two reset passes, with the boot pin at 0 and then at 1, cover both boot widths. The second pass also shows that an earlier valid window loses its valid flag.

// File: rtl/cs_decoder_pkg.sv
package cs_decoder_pkg;

  // Masked compare of one address against one window.
  function automatic logic window_hit(input logic [63:0] addr,
                                      input logic [63:0] base,
                                      input logic [63:0] mask);
    return ((addr ^ base) & mask) == 64'd0;
  endfunction

  // True when the bits above the register page are all ones.
  function automatic logic in_reg_page(input logic [63:0] addr,
                                       input int unsigned aw,
                                       input int unsigned page_w);
    logic ok;
    ok = 1'b1;
    for (int unsigned b = page_w; b < aw; b++) ok &= addr[b];
    return ok;
  endfunction

endpackage

// File: rtl/cs_cfg_bank.sv
module cs_cfg_bank #(
  parameter int unsigned N_SEL  = 16,
  parameter int unsigned ADDR_W = 24,
  localparam int unsigned IDX_W = (N_SEL > 1) ? $clog2(N_SEL) : 1
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          boot_wide_i,
  input  logic                          cfg_we_i,
  input  logic [IDX_W-1:0]              cfg_idx_i,
  input  logic [ADDR_W-1:0]             cfg_base_i,
  input  logic [ADDR_W-1:0]             cfg_mask_i,
  input  logic                          cfg_valid_i,
  input  logic                          cfg_wide_i,
  input  logic                          cfg_ro_i,
  output logic [N_SEL-1:0][ADDR_W-1:0]  base_o,
  output logic [N_SEL-1:0][ADDR_W-1:0]  mask_o,
  output logic [N_SEL-1:0]              valid_o,
  output logic [N_SEL-1:0]              wide_o,
  output logic [N_SEL-1:0]              ro_o
);

  for (genvar k = 0; k < N_SEL; k++) begin : g_win
    logic wr_k;
    assign wr_k = cfg_we_i && (cfg_idx_i == IDX_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_o[k]  <= '0;
        mask_o[k]  <= '0;
        valid_o[k] <= (k == 0);
        wide_o[k]  <= (k == 0) ? boot_wide_i : 1'b1;
        ro_o[k]    <= 1'b0;
      end else if (wr_k) begin
        base_o[k]  <= cfg_base_i;
        mask_o[k]  <= cfg_mask_i;
        valid_o[k] <= cfg_valid_i;
        wide_o[k]  <= cfg_wide_i;
        ro_o[k]    <= cfg_ro_i;
      end
    end
  end

  // R1: first edge after reset release sees only the boot window valid
  p_boot_only_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (valid_o == N_SEL'(1) && mask_o[0] == '0));

  // R11: a configuration write lands in the addressed window
  p_cfg_lands_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (valid_o[$past(cfg_idx_i)] == $past(cfg_valid_i)));

endmodule

// File: rtl/cs_match.sv
module cs_match
  import cs_decoder_pkg::*;
#(
  parameter int unsigned N_SEL  = 16,
  parameter int unsigned ADDR_W = 24
) (
  input  logic [ADDR_W-1:0]             addr_i,
  input  logic [N_SEL-1:0][ADDR_W-1:0]  base_i,
  input  logic [N_SEL-1:0][ADDR_W-1:0]  mask_i,
  input  logic [N_SEL-1:0]              valid_i,
  input  logic [N_SEL-1:0]              wide_i,
  input  logic [N_SEL-1:0]              ro_i,
  output logic [N_SEL-1:0]              hit_o,
  output logic                          ro_hit_o,
  output logic                          wide_o
);

  for (genvar k = 0; k < N_SEL; k++) begin : g_cmp
    assign hit_o[k] = valid_i[k] &&
                      window_hit(64'(addr_i), 64'(base_i[k]), 64'(mask_i[k]));
  end

  assign ro_hit_o = |(hit_o & ro_i);

  // Lowest-index hit window sets the width; no hit means 16-bit.
  always_comb begin
    wide_o = 1'b1;
    for (int k = N_SEL - 1; k >= 0; k--) begin
      if (hit_o[k]) wide_o = wide_i[k];
    end
  end

  // R4: an invalid window is never reported as hit
  p_invalid_quiet_r4: assert property (@(addr_i) 1'b1 |-> ((hit_o & ~valid_i) == '0))
    else $error("hit on invalid window");

endmodule

// File: rtl/cs_decoder.sv
module cs_decoder
  import cs_decoder_pkg::*;
#(
  parameter int unsigned N_SEL  = 16,
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned PAGE_W = 12,
  localparam int unsigned IDX_W = (N_SEL > 1) ? $clog2(N_SEL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              boot_wide_i,
  input  logic              as_i,
  input  logic              write_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              berr_en_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_base_i,
  input  logic [ADDR_W-1:0] cfg_mask_i,
  input  logic              cfg_valid_i,
  input  logic              cfg_wide_i,
  input  logic              cfg_ro_i,
  output logic [N_SEL-1:0]  cs_n_o,
  output logic              reg_sel_o,
  output logic              bus_wide_o,
  output logic              ack_o,
  output logic              berr_o
);

  logic [N_SEL-1:0][ADDR_W-1:0] base_q, mask_q;
  logic [N_SEL-1:0]             valid_q, wide_q, ro_q;
  logic [N_SEL-1:0]             hit;
  logic                         ro_hit, win_wide;

  logic [ADDR_W-1:0] addr_q;
  logic              write_q, as_q;

  // Named internal events
  logic active, in_page, violation, ext_ok;

  cs_cfg_bank #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) i_bank (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .boot_wide_i (boot_wide_i),
    .cfg_we_i    (cfg_we_i),
    .cfg_idx_i   (cfg_idx_i),
    .cfg_base_i  (cfg_base_i),
    .cfg_mask_i  (cfg_mask_i),
    .cfg_valid_i (cfg_valid_i),
    .cfg_wide_i  (cfg_wide_i),
    .cfg_ro_i    (cfg_ro_i),
    .base_o      (base_q),
    .mask_o      (mask_q),
    .valid_o     (valid_q),
    .wide_o      (wide_q),
    .ro_o        (ro_q)
  );

  cs_match #(.N_SEL(N_SEL), .ADDR_W(ADDR_W)) i_match (
    .addr_i   (addr_q),
    .base_i   (base_q),
    .mask_i   (mask_q),
    .valid_i  (valid_q),
    .wide_i   (wide_q),
    .ro_i     (ro_q),
    .hit_o    (hit),
    .ro_hit_o (ro_hit),
    .wide_o   (win_wide)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      write_q <= 1'b0;
      as_q    <= 1'b0;
    end else begin
      as_q <= as_i;
      if (as_i) begin
        addr_q  <= addr_i;
        write_q <= write_i;
      end
    end
  end

  assign active    = as_i && as_q;
  assign in_page   = in_reg_page(64'(addr_q), ADDR_W, PAGE_W);
  assign violation = active && !in_page && write_q && ro_hit;
  assign ext_ok    = active && !in_page && !violation;

  assign cs_n_o     = ext_ok ? ~hit : '1;
  assign reg_sel_o  = active && in_page;
  assign bus_wide_o = in_page ? 1'b1 : win_wide;
  assign ack_o      = active && !violation;
  assign berr_o     = violation && berr_en_i;

  // R3: the register page never drives an external select
  p_page_excl_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_sel_o |-> (cs_n_o == '1 && ack_o));

  // R8: a protection violation blocks all selects and the acknowledge
  p_prot_block_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    violation |-> (cs_n_o == '1 && !ack_o));

  // R8: bus error only with the enable high
  p_berr_gate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    berr_o |-> (berr_en_i && violation));

  // R9: nothing is driven without the strobe
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |-> (cs_n_o == '1 && !ack_o && !reg_sel_o && !berr_o));

  // R9: a strobe not yet captured gives no select
  p_capture_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_q |-> (cs_n_o == '1));

endmodule

// File: tb/test_cs_decoder.sv
module test_cs_decoder;

  localparam int N = 16;
  localparam int AW = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          boot_wide = 1'b0;
  logic          as_s = 1'b0, wr_s = 1'b0, berr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          cfg_we = 1'b0;
  logic [3:0]    cfg_idx = '0;
  logic [AW-1:0] cfg_base = '0, cfg_mask = '0;
  logic          cfg_valid = 1'b0, cfg_wide = 1'b0, cfg_ro = 1'b0;
  logic [N-1:0]  cs_n;
  logic          reg_sel, bus_wide, ack, berr;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  cs_decoder i_cs_decoder (
    .clk_i(clk), .rst_ni(rst_n), .boot_wide_i(boot_wide),
    .as_i(as_s), .write_i(wr_s), .addr_i(addr), .berr_en_i(berr_en),
    .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx), .cfg_base_i(cfg_base),
    .cfg_mask_i(cfg_mask), .cfg_valid_i(cfg_valid), .cfg_wide_i(cfg_wide),
    .cfg_ro_i(cfg_ro),
    .cs_n_o(cs_n), .reg_sel_o(reg_sel), .bus_wide_o(bus_wide),
    .ack_o(ack), .berr_o(berr)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic bw);
    @(negedge clk);
    boot_wide = bw; rst_n = 1'b0; as_s = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg(input int idx, input logic [AW-1:0] b, input logic [AW-1:0] m,
                     input logic v, input logic w, input logic ro);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 4'(idx); cfg_base = b; cfg_mask = m;
    cfg_valid = v; cfg_wide = w; cfg_ro = ro;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Drive an access and hold it to the next falling edge; captured on the rising edge between.
  task automatic access(input logic [AW-1:0] a, input logic w);
    @(negedge clk);
    as_s = 1'b1; addr = a; wr_s = w;
    @(negedge clk);
  endtask

  task automatic release_as(input string req);
    as_s = 1'b0;
    #1;
    chk(req, "idle cs_n", 32'(cs_n), 32'hFFFF);
    chk(req, "idle ack", 32'(ack), 0);
    chk(req, "idle reg_sel", 32'(reg_sel), 0);
    chk(req, "idle berr", 32'(berr), 0);
  endtask

  task automatic t_boot_narrow;
    do_reset(1'b0);
    chk("R9", "no strobe cs_n", 32'(cs_n), 32'hFFFF);
    access(24'h001234, 1'b0);
    chk("R1", "boot cs_n", 32'(cs_n), 32'hFFFE);
    chk("R2", "boot width 8", 32'(bus_wide), 0);
    chk("R1", "boot ack", 32'(ack), 1);
    release_as("R9");
    access(24'hFFEFFF, 1'b1);
    chk("R1", "below page cs_n", 32'(cs_n), 32'hFFFE);
    chk("R3", "below page reg_sel", 32'(reg_sel), 0);
    release_as("R9");
  endtask

  task automatic t_reg_page;
    access(24'hFFF000, 1'b0);
    chk("R3", "page cs_n", 32'(cs_n), 32'hFFFF);
    chk("R3", "page reg_sel", 32'(reg_sel), 1);
    chk("R3", "page ack", 32'(ack), 1);
    chk("R3", "page width", 32'(bus_wide), 1);
    release_as("R9");
    access(24'hFFFFFE, 1'b1);
    chk("R3", "page top cs_n", 32'(cs_n), 32'hFFFF);
    chk("R3", "page top reg_sel", 32'(reg_sel), 1);
    release_as("R9");
  endtask

  task automatic t_valid_gate;
    cfg(3, 24'h100000, 24'hF00000, 1'b0, 1'b0, 1'b0);
    access(24'h100040, 1'b0);
    chk("R4", "invalid win3 cs_n", 32'(cs_n), 32'hFFFE);
    release_as("R9");
    cfg(3, 24'h100000, 24'hF00000, 1'b1, 1'b0, 1'b0);
    access(24'h100040, 1'b0);
    chk("R11", "win3 enabled cs_n", 32'(cs_n), 32'hFFF6);
    chk("R7", "lowest index width", 32'(bus_wide), 0);
    release_as("R9");
    cfg(0, 24'h000000, 24'hF00000, 1'b1, 1'b1, 1'b0);
    access(24'h100040, 1'b0);
    chk("R11", "boot reprogrammed cs_n", 32'(cs_n), 32'hFFF7);
    chk("R7", "win3 narrow", 32'(bus_wide), 0);
    release_as("R9");
    access(24'h500000, 1'b0);
    chk("R7", "no hit cs_n", 32'(cs_n), 32'hFFFF);
    chk("R7", "no hit width 16", 32'(bus_wide), 1);
    release_as("R9");
  endtask

  task automatic t_mask_overlap;
    cfg(5, 24'h200003, 24'hF0000F, 1'b1, 1'b0, 1'b0);
    cfg(7, 24'h200000, 24'hF00000, 1'b1, 1'b1, 1'b0);
    access(24'h2ABC03, 1'b0);
    chk("R6", "overlap cs_n", 32'(cs_n), 32'hFF5F);
    chk("R7", "overlap width", 32'(bus_wide), 0);
    release_as("R9");
    access(24'h2ABC04, 1'b0);
    chk("R5", "mask miss cs_n", 32'(cs_n), 32'hFF7F);
    chk("R7", "win7 width", 32'(bus_wide), 1);
    release_as("R9");
  endtask

  task automatic t_protect;
    cfg(9, 24'h300000, 24'hF00000, 1'b1, 1'b1, 1'b1);
    berr_en = 1'b1;
    access(24'h300010, 1'b0);
    chk("R10", "ro read cs_n", 32'(cs_n), 32'hFDFF);
    chk("R10", "ro read ack", 32'(ack), 1);
    chk("R8", "ro read berr", 32'(berr), 0);
    release_as("R9");
    access(24'h300010, 1'b1);
    chk("R8", "ro write cs_n", 32'(cs_n), 32'hFFFF);
    chk("R8", "ro write ack", 32'(ack), 0);
    chk("R8", "ro write berr", 32'(berr), 1);
    release_as("R9");
    berr_en = 1'b0;
    access(24'h300010, 1'b1);
    chk("R8", "ro write no-en cs_n", 32'(cs_n), 32'hFFFF);
    chk("R8", "ro write no-en berr", 32'(berr), 0);
    chk("R8", "ro write no-en ack", 32'(ack), 0);
    release_as("R9");
    berr_en = 1'b1;
    access(24'h2ABC03, 1'b1);
    chk("R8", "rw write cs_n", 32'(cs_n), 32'hFF5F);
    chk("R8", "rw write ack", 32'(ack), 1);
    chk("R8", "rw write berr", 32'(berr), 0);
    release_as("R9");
    berr_en = 1'b0;
  endtask

  task automatic t_boot_wide;
    do_reset(1'b1);
    access(24'h700000, 1'b0);
    chk("R2", "boot width 16", 32'(bus_wide), 1);
    chk("R1", "boot cs_n after reset", 32'(cs_n), 32'hFFFE);
    release_as("R9");
    access(24'h100040, 1'b0);
    chk("R1", "win3 invalid after reset", 32'(cs_n), 32'hFFFE);
    release_as("R9");
  endtask

  initial begin
    t_boot_narrow();
    t_reg_page();
    t_valid_gate();
    t_mask_overlap();
    t_protect();
    t_boot_wide();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #4000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule